// File: doc/BRIEF.md
# Radio Time-Code Amplitude Keyer

This block drives the amplitude-keying control of a signal generator so that the carrier imitates a long-wave time-signal broadcast. Each minute is split into sixty one-second slots. Every slot except the last begins with a stretch of lowered carrier. The length of that stretch carries one bit: a short stretch is a 0 and a long stretch is a 1. The last slot has no lowered stretch, and that gap marks the start of the next minute.

A host supplies a 59-bit frame for each minute and a millisecond tick. It starts the sequence with a sync strobe. The keyer latches the frame at the start of each minute, so the host can write the next frame at any time during the current minute. A one-cycle request pulse near the end of the minute tells the host to update the frame. The current slot number is brought out for display or for checking. An enable input switches keying off at once.

Top module: `dcf_keyer`

## Requirements
- R1: After reset `low_flag` is 0, `sec_idx` is 0, `frame_req` is 0, and the keyer stays idle until a sync strobe arrives with `enable` high.
- R2: While running, each `tick` pulse advances a millisecond count through 0..TICKS_PER_SEC-1. When the count wraps, `sec_idx` steps by one, and after 59 it returns to 0.
- R3: A slot that carries a 0 bit holds `low_flag` high for the first SHORT_TICKS ticks of the slot, starting on the slot boundary, and low for the rest of the slot.
- R4: A slot that carries a 1 bit holds `low_flag` high for the first LONG_TICKS ticks of the slot, and low for the rest of the slot.
- R5: Slot s, for s from 0 to 58, carries bit s of the latched frame, so bit 0 is sent first.
- R6: Slot 59 never raises `low_flag`.
- R7: `frame_req` is a one-cycle pulse that appears in the cycle in which `sec_idx` becomes 58.
- R8: The frame is sampled from `frame_in` only when slot 0 starts, either on sync or when slot 59 wraps. A change to `frame_in` during a minute does not alter the bits sent in that minute.
- R9: When `enable` is low, `low_flag` is 0 in the same cycle, counting stops, and raising `enable` again does not resume keying until the next sync strobe.
- R10: A sync strobe with `enable` high restarts the keyer at slot 0, millisecond 0, and slot 0 is keyed at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Keying enable; low forces full carrier and stops counting |
| sync | input | 1 | Start strobe; restarts the keyer at slot 0 |
| tick | input | 1 | One-cycle pulse per millisecond |
| frame_in | input | 59 | Bits for the next minute, bit 0 sent first |
| low_flag | output | 1 | High while the carrier is to be reduced |
| sec_idx | output | 6 | Current slot number, 0..59 |
| frame_req | output | 1 | One-cycle pulse on entry into slot 58 |

## Verification
The hardest case to reach is the frame handover. A new frame written in the middle of a minute must stay hidden until the slot 59 to slot 0 wrap. Reaching it takes more than a full minute of ticks. The bench therefore builds the keyer with ten ticks per slot and marks of one and two ticks, so that two complete minutes fit in a short run. It writes the complement of the first frame halfway through minute zero and compares every tick against a count-derived expectation through both minutes. It then drops enable in the middle of a mark, ticks for a while, raises enable again, and checks that keying stays off until a new sync arrives.

// File: rtl/dcf_keyer.sv
module dcf_keyer #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SHORT_TICKS   = 100,
  parameter int LONG_TICKS    = 200,
  parameter int FRAME_BITS    = 59
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  sync,
  input  logic                  tick,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic                  low_flag,
  output logic [5:0]            sec_idx,
  output logic                  frame_req
);
  localparam int SLOTS = FRAME_BITS + 1;
  localparam int MW    = $clog2(TICKS_PER_SEC);

  logic [MW-1:0]         ms;
  logic [5:0]            sec;
  logic                  running;
  logic [FRAME_BITS-1:0] shadow;

  wire last_ms  = ms == MW'(TICKS_PER_SEC - 1);
  wire last_sec = sec == 6'(SLOTS - 1);
  wire cur_bit  = (sec < 6'(FRAME_BITS)) ? shadow[sec] : 1'b0;
  wire in_mark  = ms < (cur_bit ? MW'(LONG_TICKS) : MW'(SHORT_TICKS));

  assign low_flag = running & enable & ~last_sec & in_mark;
  assign sec_idx  = sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      ms        <= '0;
      sec       <= '0;
      shadow    <= '0;
      frame_req <= 1'b0;
    end else if (!enable) begin
      running   <= 1'b0;
      frame_req <= 1'b0;
    end else if (sync) begin
      running   <= 1'b1;
      ms        <= '0;
      sec       <= '0;
      shadow    <= frame_in;
      frame_req <= 1'b0;
    end else begin
      frame_req <= 1'b0;
      if (running && tick) begin
        if (last_ms) begin
          ms        <= '0;
          sec       <= last_sec ? 6'd0 : sec + 6'd1;
          frame_req <= sec == 6'(SLOTS - 3);
          if (last_sec) shadow <= frame_in;
        end else begin
          ms <= ms + MW'(1);
        end
      end
    end
  end

  // R2
  ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms < MW'(TICKS_PER_SEC));

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_idx < 6'(SLOTS));

  // R6
  no_mark_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_idx == 6'(SLOTS - 1)) |-> !low_flag);

  // R7
  frame_req_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |-> (sec_idx == 6'(SLOTS - 2)));

  // R7
  frame_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |=> !frame_req);

  // R9
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !low_flag);

  // R10
  sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sync) |=> (sec_idx == 6'd0 && ms == '0 && running));
endmodule

// File: tb/dcf_keyer_test.sv
module dcf_keyer_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 10;
  localparam int SH  = 1;
  localparam int LG  = 2;
  localparam int FB  = 59;
  localparam int MINUTE = TPS * 60;
  localparam logic [FB-1:0] FRAME_A = 59'h2AB_CDEF_0123_4567;
  localparam logic [FB-1:0] FRAME_B = ~FRAME_A;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, sync = 1'b0, tick = 1'b0;
  logic [FB-1:0] frame_in = FRAME_A;
  logic low_flag, frame_req;
  logic [5:0] sec_idx;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcf_keyer #(.TICKS_PER_SEC(TPS), .SHORT_TICKS(SH), .LONG_TICKS(LG), .FRAME_BITS(FB)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync(sync), .tick(tick),
    .frame_in(frame_in), .low_flag(low_flag), .sec_idx(sec_idx), .frame_req(frame_req));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk) sync = 1'b1;
    @(negedge clk) sync = 1'b0;
  endtask

  task automatic check_state(input int n, input logic [FB-1:0] frm, input int fr_exp);
    int s, m, bitv, fl;
    s = (n / TPS) % 60;
    m = n % TPS;
    bitv = (s < FB) ? int'(frm[s]) : 0;
    fl = (s == 59) ? 0 : (m < (bitv ? LG : SH)) ? 1 : 0;
    chk("R2 sec_idx", int'(sec_idx), s);
    if (s == 59) chk("R6 low_flag", int'(low_flag), 0);
    else if (bitv) chk("R4/R5 low_flag", int'(low_flag), fl);
    else chk("R3/R5 low_flag", int'(low_flag), fl);
    chk("R7 frame_req", int'(frame_req), fr_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 low_flag", int'(low_flag), 0);
    chk("R1 sec_idx", int'(sec_idx), 0);
    chk("R1 frame_req", int'(frame_req), 0);
    @(negedge clk) rst_n = 1'b1;
    enable = 1'b1;
    repeat (2) do_tick();
    chk("R1 idle before sync", int'(low_flag), 0);

    do_sync();
    chk("R10 sec_idx after sync", int'(sec_idx), 0);
    chk("R10 mark at slot 0", int'(low_flag), 1);
    check_state(0, FRAME_A, 0);
    for (int n = 1; n <= 2 * MINUTE; n++) begin
      do_tick();
      // R8: new frame written mid-minute, must wait for next slot 0
      if (n == MINUTE / 2) frame_in = FRAME_B;
      check_state(n, (n < MINUTE) ? FRAME_A : FRAME_B, ((n % MINUTE) == 58 * TPS) ? 1 : 0);
      @(negedge clk);
      chk("R7 one cycle", int'(frame_req), 0);
    end

    // R9: drop enable mid-mark (slot 0, bit of FRAME_B)
    chk("R9 precondition mark", int'(low_flag), 1);
    @(negedge clk) enable = 1'b0;
    #1 chk("R9 immediate low", int'(low_flag), 0);
    for (int k = 0; k < 15; k++) begin
      do_tick();
      chk("R9 held low", int'(low_flag), 0);
      chk("R9 count frozen", int'(sec_idx), 0);
    end
    @(negedge clk) enable = 1'b1;
    for (int k = 0; k < 15; k++) begin
      do_tick();
      chk("R9 no resume before sync", int'(low_flag), 0);
      chk("R9 sec frozen", int'(sec_idx), 0);
    end

    frame_in = FRAME_A;
    do_sync();
    check_state(0, FRAME_A, 0);
    for (int n = 1; n <= 5 * TPS; n++) begin
      do_tick();
      check_state(n, FRAME_A, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule